// File: doc/BRIEF.md
# Saturating Signed Byte Adder

This block adds two 8-bit two's-complement operands and returns their sum, limited to the representable range. When the true sum fits in 8 bits it comes out unchanged. When the true sum is above the positive limit the output holds at the most positive code. When it is below the negative limit the output holds at the most negative code. The block is purely combinational. It has no clock and no state, so a datapath stage places registers around it as its own timing requires.

The raw sum comes from a chain of 4-bit carry-lookahead slices. Inside each slice, every carry is formed at once from generate and propagate terms, so no carry ripples within a slice. The carry passes from one slice to the next, and the low slice receives a constant zero carry-in. After the slices, an overflow detector compares operand signs with the raw sum's sign. A clamp multiplexer then chooses between the raw sum and one of the two limit codes.

Top module: `sat_add8`

## Requirements
- R1: When the signed integer sum of the operands lies within -128..127, `sum_out` equals that sum in 8-bit two's complement.
- R2: When the signed integer sum exceeds 127 (both operands have bit 7 clear and the raw sum has bit 7 set), `sum_out` is 8'h7F.
- R3: When the signed integer sum is below -128 (both operands have bit 7 set and the raw sum has bit 7 clear), `sum_out` is 8'h80.
- R4: Operands whose bit 7 differs never saturate: `sum_out` equals `(a_in + b_in) mod 256`.
- R5: The low slice's carry-in is zero: adding 8'h00 to any operand returns that operand.
- R6: The carry out of the low 4-bit slice reaches the high slice. For example, 8'h0F + 8'h01 = 8'h10 and 8'h08 + 8'h08 = 8'h10.
- R7: The output is combinational. A change on the operands shows on `sum_out` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First operand, two's complement |
| b_in | input | 8 | Second operand, two's complement |
| sum_out | output | 8 | Saturated sum, two's complement |

## Verification
The assertions assume that the operands are stable and known when they are evaluated. Because the block has no clock, its output has settled by then. They also assume the operands are read as signed values, because the range checks compare the output with a signed integer sum. The stimulus drives only known values. It changes the operands one time unit after a bench clock edge and samples at the opposite edge. The exhaustive sweep over all 65536 operand pairs exercises every overflow class at its boundaries.

// File: rtl/sat_add_pkg.sv
// Package: sat_add_pkg
// Holds the types shared by the overflow detector and the clamp stage.
// Assumes: the overflow classes are mutually exclusive.
package sat_add_pkg;

    typedef enum logic [1:0] {
        OVF_NONE = 2'b00,
        OVF_POS  = 2'b01,
        OVF_NEG  = 2'b10
    } ovf_kind_e;

endpackage

// File: rtl/cla_slice.sv
// Module: cla_slice
// A W-bit carry-lookahead adder slice. Every internal carry is a flat
// sum-of-products of the generate/propagate terms and the carry-in.
// Assumes: W is small (the product terms grow with W squared).
module cla_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);

    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W:0]   cy;

    // Purpose: bitwise generate and propagate terms.
    always_comb begin
        gen  = a & b;
        prop = a ^ b;
    end

    // Purpose: every carry formed in parallel from gen/prop/cin.
    always_comb begin
        logic acc;
        logic chain;
        logic src;
        cy[0] = cin;
        for (int k = 1; k <= W; k++) begin
            acc = 1'b0;
            // j == 0 stands for the slice carry-in, j > 0 for gen[j-1]
            for (int j = 0; j <= k; j++) begin
                if (j < k) begin
                    src   = (j == 0) ? cin : gen[j-1];
                    chain = 1'b1;
                    for (int m = j; m < k; m++) begin
                        chain = chain & prop[m];
                    end
                    acc = acc | (src & chain);
                end else begin
                    acc = acc | gen[k-1];
                end
            end
            cy[k] = acc;
        end
    end

    // Purpose: sum bits and slice carry-out.
    always_comb begin
        s    = prop ^ cy[W-1:0];
        cout = cy[W];
    end

endmodule

// File: rtl/sat_ovf_detect.sv
// Module: sat_ovf_detect
// Classifies signed overflow from operand signs and the raw sum sign.
// Assumes: operands and raw sum are two's complement of equal width.
module sat_ovf_detect
    import sat_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [WIDTH-1:0] raw_sum,
    output ovf_kind_e        kind
);

    localparam int MSB = WIDTH - 1;

    // Purpose: same-sign operands with a flipped result sign mean overflow.
    always_comb begin
        kind = OVF_NONE;
        if (!sign_a && !sign_b && raw_sum[MSB]) begin
            kind = OVF_POS;
        end else if (sign_a && sign_b && !raw_sum[MSB]) begin
            kind = OVF_NEG;
        end
    end

endmodule

// File: rtl/sat_clamp.sv
// Module: sat_clamp
// Selects the raw sum or a limit code according to the overflow class.
// Assumes: kind comes from sat_ovf_detect for the same raw sum.
module sat_clamp
    import sat_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw_sum,
    input  ovf_kind_e        kind,
    output logic [WIDTH-1:0] result
);

    localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MAX_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    // Purpose: three-way clamp multiplexer.
    always_comb begin
        unique case (kind)
            OVF_POS: result = MAX_POS;
            OVF_NEG: result = MAX_NEG;
            default: result = raw_sum;
        endcase
    end

endmodule

// File: rtl/sat_add8.sv
// Module: sat_add8
// Saturating signed adder: a chain of lookahead slices, then an overflow
// detector and a clamp. Purely combinational; no clock or reset.
// Assumes: two's-complement operands; the first slice's carry-in is 0.
module sat_add8
    import sat_add_pkg::*;
#(
    parameter int SLICE_W  = 4,
    parameter int N_SLICES = 2
) (
    input  logic [SLICE_W*N_SLICES-1:0] a_in,
    input  logic [SLICE_W*N_SLICES-1:0] b_in,
    output logic [SLICE_W*N_SLICES-1:0] sum_out
);

    localparam int WIDTH = SLICE_W * N_SLICES;
    localparam int MSB   = WIDTH - 1;

    logic [N_SLICES:0]  slice_cy;
    logic [WIDTH-1:0]   raw_sum;
    ovf_kind_e          ovf_kind;

    assign slice_cy[0] = 1'b0;

    // Slice chain: each slice's carry-out feeds the next slice's carry-in.
    for (genvar gi = 0; gi < N_SLICES; gi++) begin : g_slice
        cla_slice #(.W(SLICE_W)) u_slice (
            .a    (a_in[gi*SLICE_W +: SLICE_W]),
            .b    (b_in[gi*SLICE_W +: SLICE_W]),
            .cin  (slice_cy[gi]),
            .s    (raw_sum[gi*SLICE_W +: SLICE_W]),
            .cout (slice_cy[gi+1])
        );
    end

    sat_ovf_detect #(.WIDTH(WIDTH)) u_detect (
        .sign_a  (a_in[MSB]),
        .sign_b  (b_in[MSB]),
        .raw_sum (raw_sum),
        .kind    (ovf_kind)
    );

    sat_clamp #(.WIDTH(WIDTH)) u_clamp (
        .raw_sum (raw_sum),
        .kind    (ovf_kind),
        .result  (sum_out)
    );

    // The final carry-out is not needed for signed saturation.
    logic unused_cy;
    assign unused_cy = slice_cy[N_SLICES];

endmodule

// File: rtl/sat_add8_chk.sv
// Module: sat_add8_chk
// Port-level checks for sat_add8, bound to every instance.
// Assumes: operands are known values whenever the output is checked.
module sat_add8_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] sum_out
);

    localparam longint HI = (longint'(1) <<< (WIDTH-1)) - 1;
    localparam longint LO = -(longint'(1) <<< (WIDTH-1));
    localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MAX_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    // Purpose: compare the output with the integer sum on every operand change.
    always_comb begin
        longint           tot;
        logic [WIDTH-1:0] wrap;
        tot  = longint'($signed(a_in)) + longint'($signed(b_in));
        wrap = a_in + b_in;
        if (tot >= LO && tot <= HI) begin
            assert_in_range_R1: assert (sum_out == wrap)
                else $error("R1 in-range sum wrong");
        end
        if (tot > HI) begin
            assert_pos_clamp_R2: assert (sum_out == MAX_POS)
                else $error("R2 positive clamp wrong");
        end
        if (tot < LO) begin
            assert_neg_clamp_R3: assert (sum_out == MAX_NEG)
                else $error("R3 negative clamp wrong");
        end
        if (a_in[WIDTH-1] != b_in[WIDTH-1]) begin
            assert_no_overflow_R4: assert (sum_out == wrap)
                else $error("R4 mixed-sign operands saturated");
        end
        if (b_in == '0) begin
            assert_zero_identity_R5: assert (sum_out == a_in)
                else $error("R5 adding zero changed operand");
        end
    end

endmodule

bind sat_add8 sat_add8_chk #(.WIDTH(SLICE_W * N_SLICES)) u_chk (
    .a_in    (a_in),
    .b_in    (b_in),
    .sum_out (sum_out)
);

// File: tb/sat_add8_test.sv
// Bench: sat_add8_test
// Drives all operand pairs, keeps expected values from an integer clamp
// model in a queue, and compares on every clock.
module sat_add8_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in  = 8'h00;
    logic [7:0] b_in  = 8'h00;
    logic [7:0] sum_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    logic [7:0] exp_q[$];

    sat_add8 uut (
        .a_in    (a_in),
        .b_in    (b_in),
        .sum_out (sum_out)
    );

    // Purpose: free-running bench clock.
    always #(CLK_PERIOD/2) clk = ~clk;

    // Purpose: watchdog; an expired run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    function automatic logic [7:0] ref_sum(input logic [7:0] a, input logic [7:0] b);
        int t;
        t = int'($signed(a)) + int'($signed(b));
        if (t > 127)  t = 127;
        if (t < -128) t = -128;
        return 8'(t);
    endfunction

    function automatic string classify(input logic [7:0] a, input logic [7:0] b);
        int t;
        t = int'($signed(a)) + int'($signed(b));
        if (a[7] != b[7]) return "R4";
        if (t > 127)      return "R2";
        if (t < -128)     return "R3";
        return "R1";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: a=%h b=%h actual %h expected %h", tag, a_in, b_in, act, expv);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        #1;
        a_in = a;
        b_in = b;
        exp_q.push_back(ref_sum(a, b));
        @(negedge clk);
        check(classify(a, b), sum_out, exp_q.pop_front());
    endtask

    initial begin
        // Reset phase: zero operands give a zero sum.
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", sum_out, 8'h00);
        rst_n = 1'b1;

        // Directed boundaries.
        apply(8'h7F, 8'h01);  // R2 just over
        apply(8'h7E, 8'h01);  // R1 exact limit
        apply(8'h80, 8'hFF);  // R3 just under
        apply(8'h81, 8'hFF);  // R1 exact negative limit
        apply(8'h7F, 8'h80);  // R4 extremes mixed

        // R6: carry between slices.
        apply(8'h0F, 8'h01);
        check("R6", sum_out, 8'h10);
        apply(8'h08, 8'h08);
        check("R6", sum_out, 8'h10);

        // R5: zero carry-in, adding zero is identity.
        apply(8'h5A, 8'h00);
        check("R5", sum_out, 8'h5A);

        // R7: output follows operands between clock edges.
        @(negedge clk);
        a_in = 8'h11; b_in = 8'h22;
        #1;
        check("R7", sum_out, 8'h33);
        a_in = 8'h60; b_in = 8'h60;
        #1;
        check("R7", sum_out, 8'h7F);

        // Exhaustive sweep over every operand pair (R1..R4).
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] pr;
            pr = 16'(i);
            apply(pr[15:8], pr[7:0]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule